// File: doc/BRIEF.md
# Fracturable LUT4 Logic Cluster

This block is one logic tile of a small programmable fabric. It holds eight identical logic cells that share one clock. Each cell has a 16-entry truth table, a two-input carry selector and one flip-flop. Each cell takes a 4-bit data bus and drives two outputs: a combinational one taken straight from the 4-input lookup, and a registered one. The same truth table also yields two 2-input lookups, a propagate term and a generate term, and these feed the cell's carry selector. A ripple carry enters cell 0, passes through every cell in turn and leaves from the last cell. With that path, a cluster can hold one bit-slice of an adder per cell.

All configuration is static and arrives as parallel inputs: the truth tables, the per-cell select that puts the incoming carry on lookup input 2, and the per-cell select that lets data input 3 bypass the lookup and go straight into the flip-flop. Loading the configuration, routing and I/O belong to the fabric around the cluster. The block has no state machine. The only sequential elements are the eight flip-flops, each with a synchronous active-high clear.

Top module: `lcl_cluster`

## Requirements
- R1: For cell i, `comb_out[i]` equals `tt_cfg[16i +: 16]` indexed by {d3, x, d1, d0}. The data bits are d0..d3 = `data_in[4i+0..4i+3]`. x is d2 when `cin_sel_cfg[i]`=0 and the cell's incoming carry when it is 1.
- R2: Each cell forms a generate term g = truth table bit {d1,d0} (entries 0..3) and a propagate term p = truth table bit 4+{d1,d0} (entries 4..7).
- R3: A cell's outgoing carry equals its incoming carry when p=1, and equals g when p=0.
- R4: Cell 0 takes its incoming carry from `carry_in`. Each later cell takes the outgoing carry of the cell below it. `carry_out` is the outgoing carry of the last cell.
- R5: On each rising clock edge outside reset, `reg_out[i]` loads `comb_out[i]` when `ff_sel_cfg[i]`=0 and data bit d3 of cell i when it is 1.
- R6: While `rst` is high at a rising edge, every `reg_out` bit becomes 0. The combinational outputs are unaffected.
- R7: With every cell set to truth table 16'h9668, carry select 1, d3=1, d0=a[i] and d1=b[i], the cluster gives `comb_out` = (a+b+`carry_in`) mod 256 and `carry_out` = bit 8 of that sum. The sum appears on `reg_out` one edge later.
- R8: When `cin_sel_cfg`=0 for a cell, `carry_in` has no effect on that cell's `comb_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of the flip-flops |
| data_in | input | 32 | Four data bits per cell, cell i at [4i+3:4i] |
| carry_in | input | 1 | Carry into cell 0 |
| tt_cfg | input | 128 | 16-bit truth table per cell, cell i at [16i+15:16i] |
| cin_sel_cfg | input | 8 | Per cell: 1 puts the incoming carry on lookup input 2 |
| ff_sel_cfg | input | 8 | Per cell: 1 feeds data bit 3 to the flip-flop |
| comb_out | output | 8 | Lookup output per cell |
| reg_out | output | 8 | Flip-flop output per cell |
| carry_out | output | 1 | Carry out of the last cell |

## Verification
The lookup is swept across all 16 index values under two irregular truth tables, so that any swapped or misordered index bit gives a wrong entry. The carry path is driven in two ways. In one, every cell propagates. In the other, a single mid-chain cell generates or kills the carry, so the position where the value changes on `comb_out` shows whether the chain order is right. The final carry is also swept over all propagate/generate entries of one cell, which tells the two fractured halves apart. Adder vectors cover no carry, a full ripple from bit 0, alternating bits and an all-ones overflow. Mixed flip-flop selects tell the bypass path apart from the lookup path.

// File: rtl/lcl_pkg.sv
package lcl_pkg;
    localparam int LUT_IN = 4;
    localparam int TT_W   = 1 << LUT_IN;

    typedef logic [TT_W-1:0] tt_t;

    // fractured half-lookups feeding the carry selector
    typedef struct packed {
        logic p;   // propagate: entries 4..7
        logic g;   // generate: entries 0..3
    } pg_t;
endpackage

// File: rtl/lcl_lut4_frac.sv
module lcl_lut4_frac
    import lcl_pkg::*;
(
    input  tt_t               tt,
    input  logic [LUT_IN-1:0] idx,
    output logic              f4,
    output pg_t               half
);
    localparam int HALF_W = LUT_IN / 2;

    always_comb begin
        f4     = tt[idx];
        half.g = tt[{2'b00, idx[HALF_W-1:0]}];
        half.p = tt[{2'b01, idx[HALF_W-1:0]}];
    end
endmodule

// File: rtl/lcl_carry_sel.sv
module lcl_carry_sel
    import lcl_pkg::*;
(
    input  pg_t  pg,
    input  logic ci,
    output logic co
);
    always_comb begin
        co = pg.p ? ci : pg.g;
    end
endmodule

// File: rtl/lcl_cell.sv
module lcl_cell
    import lcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LUT_IN-1:0] din,
    input  logic              ci,
    input  tt_t               tt,
    input  logic              cin_sel,
    input  logic              ff_sel,
    output logic              comb,
    output logic              q,
    output logic              co,
    output pg_t               pg
);
    logic [LUT_IN-1:0] lut_idx;
    logic              ff_d;

    always_comb begin
        lut_idx = {din[3], (cin_sel ? ci : din[2]), din[1:0]};
    end

    lcl_lut4_frac u_lut (
        .tt   (tt),
        .idx  (lut_idx),
        .f4   (comb),
        .half (pg)
    );

    lcl_carry_sel u_carry (
        .pg (pg),
        .ci (ci),
        .co (co)
    );

    always_comb begin
        ff_d = ff_sel ? din[3] : comb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= ff_d;
        end
    end
endmodule

// File: rtl/lcl_cluster.sv
module lcl_cluster
    import lcl_pkg::*;
#(
    parameter int NUM_CELLS = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CELLS*4-1:0]    data_in,
    input  logic                      carry_in,
    input  logic [NUM_CELLS*16-1:0]   tt_cfg,
    input  logic [NUM_CELLS-1:0]      cin_sel_cfg,
    input  logic [NUM_CELLS-1:0]      ff_sel_cfg,
    output logic [NUM_CELLS-1:0]      comb_out,
    output logic [NUM_CELLS-1:0]      reg_out,
    output logic                      carry_out
);
    localparam int DIN_W = LUT_IN;

    logic [NUM_CELLS:0]   carry_chain;
    logic [NUM_CELLS-1:0] prop_vec;
    logic [NUM_CELLS-1:0] gen_vec;

    assign carry_chain[0] = carry_in;

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        pg_t cell_pg;

        lcl_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .din     (data_in[i*DIN_W +: DIN_W]),
            .ci      (carry_chain[i]),
            .tt      (tt_cfg[i*TT_W +: TT_W]),
            .cin_sel (cin_sel_cfg[i]),
            .ff_sel  (ff_sel_cfg[i]),
            .comb    (comb_out[i]),
            .q       (reg_out[i]),
            .co      (carry_chain[i+1]),
            .pg      (cell_pg)
        );

        assign prop_vec[i] = cell_pg.p;
        assign gen_vec[i]  = cell_pg.g;
    end

    assign carry_out = carry_chain[NUM_CELLS];
endmodule

// File: rtl/lcl_cluster_chk.sv
module lcl_cluster_chk #(
    parameter int NUM_CELLS = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_CELLS*4-1:0]  data_in,
    input logic [NUM_CELLS*16-1:0] tt_cfg,
    input logic [NUM_CELLS-1:0]    cin_sel_cfg,
    input logic [NUM_CELLS-1:0]    ff_sel_cfg,
    input logic [NUM_CELLS-1:0]    comb_out,
    input logic [NUM_CELLS-1:0]    reg_out,
    input logic [NUM_CELLS:0]      chain,
    input logic [NUM_CELLS-1:0]    prop_vec,
    input logic [NUM_CELLS-1:0]    gen_vec
);
    // R6: clear on reset
    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (reg_out == '0));

    // R8: carry_in cannot reach comb_out when no cell selects the carry
    assert_cin_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        ((cin_sel_cfg == '0) && $stable(cin_sel_cfg) && $stable(data_in)
         && $stable(tt_cfg)) |-> $stable(comb_out));

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_chk
        // R5: flip-flop input select
        assert_ff_load_R5: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (reg_out[i] == ($past(ff_sel_cfg[i]) ? $past(data_in[4*i+3])
                                                           : $past(comb_out[i]))));
        // R3: carry propagates when p=1
        assert_carry_prop_R3: assert property (@(posedge clk) disable iff (rst)
            prop_vec[i] |-> (chain[i+1] == chain[i]));
        // R3: carry takes the generate term when p=0
        assert_carry_gen_R3: assert property (@(posedge clk) disable iff (rst)
            !prop_vec[i] |-> (chain[i+1] == gen_vec[i]));
    end
endmodule

bind lcl_cluster lcl_cluster_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .data_in     (data_in),
    .tt_cfg      (tt_cfg),
    .cin_sel_cfg (cin_sel_cfg),
    .ff_sel_cfg  (ff_sel_cfg),
    .comb_out    (comb_out),
    .reg_out     (reg_out),
    .chain       (carry_chain),
    .prop_vec    (prop_vec),
    .gen_vec     (gen_vec)
);

// File: tb/lcl_cluster_tb.sv
module lcl_cluster_tb;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N*4-1:0]  data_in = '0;
    logic            carry_in = 1'b0;
    logic [N*16-1:0] tt_cfg = '0;
    logic [N-1:0]    cin_sel_cfg = '0;
    logic [N-1:0]    ff_sel_cfg = '0;
    logic [N-1:0]    comb_out;
    logic [N-1:0]    reg_out;
    logic            carry_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lcl_cluster #(.NUM_CELLS(N)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .data_in     (data_in),
        .carry_in    (carry_in),
        .tt_cfg      (tt_cfg),
        .cin_sel_cfg (cin_sel_cfg),
        .ff_sel_cfg  (ff_sel_cfg),
        .comb_out    (comb_out),
        .reg_out     (reg_out),
        .carry_out   (carry_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // byte k supplies data bit k of every cell
    function automatic logic [N*4-1:0] pack(input logic [7:0] b0, input logic [7:0] b1,
                                            input logic [7:0] b2, input logic [7:0] b3);
        logic [N*4-1:0] v;
        for (int i = 0; i < N; i++) begin
            v[4*i+0] = b0[i];
            v[4*i+1] = b1[i];
            v[4*i+2] = b2[i];
            v[4*i+3] = b3[i];
        end
        return v;
    endfunction

    function automatic logic [N*16-1:0] all_tt(input logic [15:0] t);
        logic [N*16-1:0] v;
        for (int i = 0; i < N; i++) v[16*i +: 16] = t;
        return v;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R6 reset state", {24'h0, reg_out}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_lut4();
        logic [15:0] t3 = 16'hB36D;
        logic [15:0] t0 = 16'h8421;
        @(negedge clk);
        cin_sel_cfg = '0;
        tt_cfg = '0;
        tt_cfg[16*3 +: 16] = t3;
        tt_cfg[0 +: 16] = t0;
        for (int v = 0; v < 16; v++) begin
            data_in = '0;
            data_in[12 +: 4] = v[3:0];
            data_in[0 +: 4] = v[3:0];
            #1;
            chk("R1 lut4 cell3", {31'h0, comb_out[3]}, {31'h0, t3[v]});
            chk("R1 lut4 cell0", {31'h0, comb_out[0]}, {31'h0, t0[v]});
            #1;
        end
    endtask

    task automatic t_chain();
        // cells output lookup input 2 (d3=1); propagate except cell 4
        @(negedge clk);
        cin_sel_cfg = '1;
        data_in = pack(8'h00, 8'h00, 8'h00, 8'hFF);
        tt_cfg = all_tt(16'hF0F0);
        carry_in = 1'b1;
        #1;
        chk("R4 all propagate comb", {24'h0, comb_out}, 32'hFF);
        chk("R4 all propagate cout", {31'h0, carry_out}, 32'h1);
        tt_cfg[16*4 +: 16] = 16'hF00F;
        carry_in = 1'b0;
        #1;
        chk("R4 generate at cell4", {24'h0, comb_out}, 32'hE0);
        chk("R3 generate cout", {31'h0, carry_out}, 32'h1);
        tt_cfg[16*4 +: 16] = 16'hF000;
        carry_in = 1'b1;
        #1;
        chk("R4 kill at cell4", {24'h0, comb_out}, 32'h1F);
        chk("R3 kill cout", {31'h0, carry_out}, 32'h0);
    endtask

    task automatic t_halves();
        logic [15:0] t7 = 16'h00A6;
        logic exp;
        @(negedge clk);
        tt_cfg = all_tt(16'h00F0);
        tt_cfg[16*7 +: 16] = t7;
        cin_sel_cfg = '0;
        for (int c = 0; c < 2; c++) begin
            for (int v = 0; v < 4; v++) begin
                carry_in = c[0];
                data_in = '0;
                data_in[28 +: 2] = v[1:0];
                #1;
                exp = t7[4+v] ? c[0] : t7[v];
                chk("R2 half lookups via cout", {31'h0, carry_out}, {31'h0, exp});
                #1;
            end
        end
    endtask

    task automatic t_adder(input logic [7:0] a, input logic [7:0] b, input logic ci);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b} + {8'h0, ci};
        @(negedge clk);
        tt_cfg = all_tt(16'h9668);
        cin_sel_cfg = '1;
        ff_sel_cfg = '0;
        carry_in = ci;
        data_in = pack(a, b, 8'h00, 8'hFF);
        #1;
        chk("R7 adder sum", {24'h0, comb_out}, {24'h0, s[7:0]});
        chk("R7 adder carry", {31'h0, carry_out}, {31'h0, s[8]});
        @(posedge clk);
        #1;
        chk("R7 registered sum", {24'h0, reg_out}, {24'h0, s[7:0]});
    endtask

    task automatic t_ffmux();
        @(negedge clk);
        tt_cfg = '0;
        cin_sel_cfg = '0;
        ff_sel_cfg = '1;
        data_in = pack(8'h00, 8'h00, 8'h00, 8'hC5);
        @(posedge clk);
        #1;
        chk("R5 bypass d3", {24'h0, reg_out}, 32'hC5);
        @(negedge clk);
        tt_cfg = all_tt(16'hFFFF);
        ff_sel_cfg = 8'h0F;
        data_in = pack(8'h00, 8'h00, 8'h00, 8'h05);
        @(posedge clk);
        #1;
        chk("R5 mixed selects", {24'h0, reg_out}, 32'hF5);
    endtask

    task automatic t_sync_clear();
        @(negedge clk);
        rst = 1'b1;
        #1;
        chk("R6 clear waits for edge", {24'h0, reg_out}, 32'hF5);
        @(posedge clk);
        #1;
        chk("R6 cleared", {24'h0, reg_out}, 32'h0);
        chk("R6 comb unaffected", {24'h0, comb_out}, 32'hFF);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_cin_ignored();
        @(negedge clk);
        tt_cfg = all_tt(16'hF0F0);
        cin_sel_cfg = '0;
        data_in = pack(8'h00, 8'h00, 8'h3C, 8'hFF);
        carry_in = 1'b0;
        #1;
        chk("R8 carry 0", {24'h0, comb_out}, 32'h3C);
        @(negedge clk);
        carry_in = 1'b1;
        #1;
        chk("R8 carry 1", {24'h0, comb_out}, 32'h3C);
    endtask

    initial begin
        t_reset();
        t_lut4();
        t_chain();
        t_halves();
        t_adder(8'h00, 8'h00, 1'b0);
        t_adder(8'hFF, 8'h00, 1'b1);
        t_adder(8'h5A, 8'hA5, 1'b1);
        t_adder(8'hC8, 8'h64, 1'b0);
        t_adder(8'hFF, 8'hFF, 1'b1);
        t_ffmux();
        t_sync_clear();
        t_cin_ignored();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule